// File: doc/BRIEF.md
# GPIO Port with Interrupt Controller

A 32-pin general-purpose I/O port with a register bank on a plain 32-bit read/write bus. Software sets the value driven on each pin and chooses, pin by pin, whether that pin is an output. The synchronized level of every pad can be read back at any time.

Each pin also feeds an interrupt detector. A 2-bit field picks one of four triggers: low level, high level, rising edge or falling edge. Every detected event sets a bit in a status register. That bit sets whatever the mask says, so software can poll pins that are masked. Software clears a status bit by writing a one to it. Each pin has a mask bit, and a pin raises an interrupt only when its status bit and its mask bit are both 1. There are two interrupt lines: one ORs the enabled pending bits of pins 0 to 15, the other those of pins 16 to 31.

Bus writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Reads are combinational from `bus_addr`.

Top module: `gpio_port_irq`

## Requirements
- R1: At reset the data (0x00), direction (0x04), low trigger (0x0C), high trigger (0x10), mask (0x14) and status (0x18) registers read zero, both interrupt lines are low, and any offset outside the seven mapped ones reads zero.
- R2: `pad_out` equals the data register and `pad_oe` equals the direction register, where a 1 marks a pin as output. Both registers read back at their offsets.
- R3: Offset 0x08 returns `pad_in` through a two-flop synchronizer. A change driven between edges is not yet visible after one rising edge and is visible after two. Writes to 0x08 have no effect.
- R4: Pin p takes its trigger from bits [2*(p mod 16)+1 : 2*(p mod 16)] of 0x0C when p < 16 and of 0x10 otherwise. Code 0 is low level and code 1 is high level. A level trigger sets the status bit while the synchronized level matches.
- R5: Code 2 is rising edge and code 3 is falling edge. An edge compares the synchronized level with its value one clock earlier, and it sets the status bit once per qualifying transition and never while the level is steady.
- R6: Writing 1 to a bit of the status register clears that bit. Writing 0 to it leaves it unchanged.
- R7: A level-triggered status bit sets again after being cleared for as long as its level persists.
- R8: When an event and a clear of the same status bit fall in the same cycle, the bit ends up 1.
- R9: A status bit latches whatever its mask bit is. A pending bit whose mask is 0 drives no interrupt.
- R10: `irq_lo` is the OR over pins 0 to 15 of status AND mask, and `irq_hi` is the same OR over pins 16 to 31. A mask bit of 1 enables its pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The bench times a write-one-to-clear so that it lands on the same edge as a fresh rising event. A design that lets the clear win would drop that event and read 0. It holds a high level across a clear to catch a design that treats levels as one-shot. It holds an edge-configured pin steady to catch a design that re-fires edges, and it checks that the synchronizer is exactly two flops deep. It sets mask bits 15 and 16 one at a time to catch a design that routes a pin to the wrong half, and it checks a masked pin that is pending to catch a design that gates latching with the mask.

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   pad_in,
  output logic [31:0]   pad_out,
  output logic [31:0]   pad_oe,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam int N = 32;
  localparam int H = N / 2;
  localparam logic [AW-1:0] A_DATA = AW'(8'h00);
  localparam logic [AW-1:0] A_DIR  = AW'(8'h04);
  localparam logic [AW-1:0] A_PAD  = AW'(8'h08);
  localparam logic [AW-1:0] A_TLO  = AW'(8'h0C);
  localparam logic [AW-1:0] A_THI  = AW'(8'h10);
  localparam logic [AW-1:0] A_MASK = AW'(8'h14);
  localparam logic [AW-1:0] A_STAT = AW'(8'h18);

  logic [N-1:0] dout, dir, mask, stat;
  logic [N-1:0] cfg_lo, cfg_hi;
  logic [N-1:0] sync1, sync2, prev;
  logic [N-1:0] evt, clr;
  logic         wen;

  assign wen = bus_sel & bus_wr;
  assign clr = (wen && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; dir <= '0; mask <= '0; cfg_lo <= '0; cfg_hi <= '0;
    end else if (wen) begin
      case (bus_addr)
        A_DATA: dout   <= bus_wdata;
        A_DIR:  dir    <= bus_wdata;
        A_TLO:  cfg_lo <= bus_wdata;
        A_THI:  cfg_hi <= bus_wdata;
        A_MASK: mask   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [1:0] trig;
    if (i < H) begin : g_lo
      assign trig = cfg_lo[2*i +: 2];
    end else begin : g_hi
      assign trig = cfg_hi[2*(i-H) +: 2];
    end
    always_comb begin
      case (trig)
        2'd0:    evt[i] = ~sync2[i];
        2'd1:    evt[i] =  sync2[i];
        2'd2:    evt[i] =  sync2[i] & ~prev[i];
        default: evt[i] = ~sync2[i] &  prev[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | evt;
  end

  assign pad_out = dout;
  assign pad_oe  = dir;
  assign irq_lo  = |(stat[H-1:0] & mask[H-1:0]);
  assign irq_hi  = |(stat[N-1:H] & mask[N-1:H]);

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = dout;
      A_DIR:   bus_rdata = dir;
      A_PAD:   bus_rdata = sync2;
      A_TLO:   bus_rdata = cfg_lo;
      A_THI:   bus_rdata = cfg_hi;
      A_MASK:  bus_rdata = mask;
      A_STAT:  bus_rdata = stat;
      default: bus_rdata = '0;
    endcase
  end

  AST_SET_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stat & ~$past(stat) & ~$past(evt)) == '0)); // R4
  AST_CLEAR_ONLY_ON_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~stat & $past(stat) & ~$past(clr)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(evt) & ~stat) == '0)); // R8
  AST_IRQ_LO_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (mask[H-1:0] != '0)); // R10
  AST_IRQ_HI_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (mask[N-1:H] != '0)); // R10
endmodule

// File: tb/gpio_port_irq_tb.sv
module gpio_port_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] sh_lo = '0, sh_hi = '0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_port_irq #(.AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  // {pin[4:0], trig[1:0], start, end, expected}
  localparam logic [9:0] VEC [0:8] = '{
    {5'd4,  2'd0, 1'b1, 1'b0, 1'b1},
    {5'd6,  2'd0, 1'b1, 1'b1, 1'b0},
    {5'd12, 2'd1, 1'b0, 1'b1, 1'b1},
    {5'd14, 2'd1, 1'b0, 1'b0, 1'b0},
    {5'd18, 2'd2, 1'b0, 1'b1, 1'b1},
    {5'd20, 2'd2, 1'b1, 1'b0, 1'b0},
    {5'd25, 2'd3, 1'b1, 1'b0, 1'b1},
    {5'd28, 2'd3, 1'b0, 1'b1, 1'b0},
    {5'd31, 2'd2, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_trig(int p, logic [1:0] t);
    if (p < 16) begin sh_lo[2*p +: 2] = t; wr(8'h0C, sh_lo); end
    else begin sh_hi[2*(p-16) +: 2] = t; wr(8'h10, sh_hi); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, read combinationally while reset is held
    #2;
    bus_addr = 8'h00; #1; chk("R1 data", bus_rdata, 0);
    bus_addr = 8'h04; #1; chk("R1 dir", bus_rdata, 0);
    bus_addr = 8'h0C; #1; chk("R1 trig lo", bus_rdata, 0);
    bus_addr = 8'h10; #1; chk("R1 trig hi", bus_rdata, 0);
    bus_addr = 8'h14; #1; chk("R1 mask", bus_rdata, 0);
    bus_addr = 8'h18; #1; chk("R1 status", bus_rdata, 0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h1C, rv); chk("R1 unmapped 0x1C", rv, 0);
    rd(8'h40, rv); chk("R1 unmapped 0x40", rv, 0);

    // R2: data and direction
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(8'h00, rv); chk("R2 data rb", rv, 32'hA5A5_0F0F);
    rd(8'h04, rv); chk("R2 dir rb", rv, 32'hFFFF_0000);

    // R3: two-flop synchronizer depth, pad status read-only
    @(negedge clk); pad = 32'h1234_5678;
    @(posedge clk); @(negedge clk);
    bus_addr = 8'h08; #1; chk("R3 after one edge", bus_rdata, 0);
    @(posedge clk); @(negedge clk);
    bus_addr = 8'h08; #1; chk("R3 after two edges", bus_rdata, 32'h1234_5678);
    wr(8'h08, 32'h0);
    rd(8'h08, rv); chk("R3 write ignored", rv, 32'h1234_5678);
    @(negedge clk); pad = '0;
    cyc(4);

    // R4 / R5: table of trigger types and transitions
    for (int v = 0; v < 9; v++) begin
      int p;
      p = int'(VEC[v][9:5]);
      @(negedge clk); pad[p] = VEC[v][2];
      cyc(4);
      set_trig(p, VEC[v][4:3]);
      cyc(4);
      wr(8'h18, 32'h1 << p);
      @(negedge clk); pad[p] = VEC[v][1];
      cyc(4);
      rd(8'h18, rv);
      chk($sformatf("R4 R5 vector %0d pin %0d", v, p), {31'd0, rv[p]}, {31'd0, VEC[v][0]});
    end
    rd(8'h0C, rv); chk("R4 trig lo field layout", rv, sh_lo);
    rd(8'h10, rv); chk("R4 trig hi field layout", rv, sh_hi);

    // R6 / R5: write-one-to-clear on a rising-edge pin
    set_trig(8, 2'd2);
    @(negedge clk); pad[8] = 1'b1;
    cyc(4);
    rd(8'h18, rv); chk("R5 rise sets", {31'd0, rv[8]}, 1);
    wr(8'h18, 32'h0);
    rd(8'h18, rv); chk("R6 write 0 keeps", {31'd0, rv[8]}, 1);
    wr(8'h18, 32'h1 << 8);
    rd(8'h18, rv); chk("R6 write 1 clears", {31'd0, rv[8]}, 0);
    cyc(4);
    rd(8'h18, rv); chk("R5 steady high no refire", {31'd0, rv[8]}, 0);

    // R7: level re-asserts after clear
    set_trig(9, 2'd1);
    @(negedge clk); pad[9] = 1'b1;
    cyc(4);
    wr(8'h18, 32'h1 << 9);
    cyc(2);
    rd(8'h18, rv); chk("R7 level re-sets", {31'd0, rv[9]}, 1);

    // R8: event and clear in the same cycle
    set_trig(10, 2'd2);
    cyc(4);
    wr(8'h18, 32'h1 << 10);
    rd(8'h18, rv); chk("R8 precondition clear", {31'd0, rv[10]}, 0);
    @(negedge clk); pad[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(8'h18, 32'h1 << 10);
    rd(8'h18, rv); chk("R8 set wins over clear", {31'd0, rv[10]}, 1);

    // R9 / R10: mask gating and half split
    set_trig(5, 2'd2);
    set_trig(22, 2'd2);
    cyc(4);
    wr(8'h18, (32'h1 << 5) | (32'h1 << 22));
    @(negedge clk); pad[5] = 1'b1; pad[22] = 1'b1;
    cyc(4);
    rd(8'h18, rv); chk("R9 masked pin latches", {30'd0, rv[22], rv[5]}, 2'b11);
    chk("R9 masked no irq", {30'd0, irq_hi, irq_lo}, 0);
    wr(8'h14, 32'h1 << 5);
    chk("R10 pin5 -> irq_lo", {30'd0, irq_hi, irq_lo}, 2'b01);
    wr(8'h14, 32'h1 << 22);
    chk("R10 pin22 -> irq_hi", {30'd0, irq_hi, irq_lo}, 2'b10);
    wr(8'h18, 32'h1 << 22);
    chk("R10 cleared drops irq_hi", {30'd0, irq_hi, irq_lo}, 0);
    wr(8'h14, 32'h1 << 15);
    chk("R10 pin15 boundary", {30'd0, irq_hi, irq_lo}, 2'b01);
    wr(8'h14, 32'h1 << 16);
    chk("R10 pin16 boundary", {30'd0, irq_hi, irq_lo}, 2'b10);

    finish_run();
  end
endmodule